// File: doc/BRIEF.md
# Key-Locked Countdown Reset Watchdog

This block is a countdown watchdog for a power-management device. It is reached through a 16-bit register port, and it counts enabled pulses of a 32.768 kHz tick. The timeout register pair, the control register and the run state are write-protected. Software opens them by writing a 16-bit key to the lock register. It then loads a 32-bit timeout as two 16-bit halves and sets the run and reset-enable bits in the control register.

While the block runs, each enabled tick takes one off the counter. When the count runs out, the run bit clears. If reset generation is enabled, a reset pulse of a fixed number of ticks is also driven. Software kicks the watchdog by writing a fresh timeout half while the block runs. The next tick then reloads the counter instead of decrementing it. A module-enable input gates both register writes and counting. A clock-enable input gates counting only.

Top module: `keylock_wdt`

## Requirements
- R1: After reset all four registers read as zero, the block is locked (lock register reads 0) and `wdt_rst_o` is low.
- R2: While locked, writes to offsets 0x80, 0x84 and 0x88 leave the read-back value unchanged, and a control write does not start the counter.
- R3: Writing 0xE551 to offset 0xA0 unlocks the block, and the lock register then reads 1 in bit 0. Writing any other value there locks it again and it reads 0.
- R4: A control write that sets bit 1 while the block is stopped loads the counter with {offset 0x84, offset 0x80} as one 32-bit value, high half first.
- R5: Each enabled tick decrements the counter by one. For a load value L, expiry happens on enabled tick max(L,1) after the start. This holds when the count spans the high half (L = 0x0001_0000).
- R6: On expiry with control bit 3 set, `wdt_rst_o` rises in the cycle after the expiring tick. It stays high for exactly 4 further enabled ticks and falls after the 4th.
- R7: Expiry clears control bit 1. With bit 3 clear, expiry produces no reset pulse.
- R8: A write to offset 0x80 or 0x84 while the block runs makes the next enabled tick reload the counter with the new value and not decrement it. Expiry then comes L ticks after that reload.
- R9: A tick counts only while both `clk_en_i` and `mod_en_i` are high. Register writes take effect only while `mod_en_i` is high.
- R10: Read-back maps 0x80 to the low timeout half and 0x84 to the high half. 0x88 returns run in bit 1 and reset-enable in bit 3, with all other bits zero. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz tick, one-cycle enable per period |
| mod_en_i | input | 1 | Module (interface) enable |
| clk_en_i | input | 1 | Work-clock enable for counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 8 | Register read offset |
| rd_data_o | output | 16 | Register read data (combinational) |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
The bench sweeps every load value from 0 to 12 and checks that expiry falls exactly on tick max(L,1). This separates an off-by-one at the zero boundary from a plain decrement error. A load of 0x0001_0000 with the tick held high shows that the high half joins the count. A kick in the middle of a count, ticks with each enable low, and an expiry with reset disabled each move the expiry tick or suppress the pulse by a computed amount. Locked writes, wrong keys and writes with the module disabled are checked through read-back.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 2 * REG_W;

  localparam logic [ADDR_W-1:0] OFS_TMO_LO = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_TMO_HI = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 8'hA0;

  localparam int BIT_RUN   = 1;
  localparam int BIT_RSTEN = 3;

  localparam logic [REG_W-1:0] OPEN_KEY = 16'hE551;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              expire_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [CNT_W-1:0]  tmo_o,
  output logic              run_o,
  output logic              rsten_o,
  output logic              start_o,
  output logic              kick_o
);
  logic             open_q, open_n;
  logic [REG_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic             run_q, run_n, rsten_q, rsten_n;
  logic             wr_ok, cfg_ok, wr_lo, wr_hi, wr_ctl;

  always_comb begin
    wr_ok   = wr_en_i & mod_en_i;
    cfg_ok  = wr_ok & open_q;
    wr_lo   = cfg_ok & (wr_addr_i == OFS_TMO_LO);
    wr_hi   = cfg_ok & (wr_addr_i == OFS_TMO_HI);
    wr_ctl  = cfg_ok & (wr_addr_i == OFS_CTRL);
    open_n  = open_q;
    lo_n    = wr_lo ? wr_data_i : lo_q;
    hi_n    = wr_hi ? wr_data_i : hi_q;
    run_n   = run_q;
    rsten_n = rsten_q;
    if (wr_ok && (wr_addr_i == OFS_LOCK))
      open_n = (wr_data_i == OPEN_KEY);
    if (wr_ctl) begin
      run_n   = wr_data_i[BIT_RUN];
      rsten_n = wr_data_i[BIT_RSTEN];
    end else if (expire_i) begin
      run_n = 1'b0;
    end
    start_o = wr_ctl & wr_data_i[BIT_RUN] & ~run_q;
    kick_o  = (wr_lo | wr_hi) & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      run_q   <= 1'b0;
      rsten_q <= 1'b0;
    end else begin
      open_q  <= open_n;
      lo_q    <= lo_n;
      hi_q    <= hi_n;
      run_q   <= run_n;
      rsten_q <= rsten_n;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFS_TMO_LO: rd_data_o = lo_q;
      OFS_TMO_HI: rd_data_o = hi_q;
      OFS_CTRL: begin
        rd_data_o[BIT_RUN]   = run_q;
        rd_data_o[BIT_RSTEN] = rsten_q;
      end
      OFS_LOCK:   rd_data_o[0] = open_q;
      default:    rd_data_o = '0;
    endcase
  end

  assign tmo_o   = {hi_q, lo_q};
  assign run_o   = run_q;
  assign rsten_o = rsten_q;

  // R2: a locked block keeps its timeout halves
  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !open_q) |=> ($stable(lo_q) && $stable(hi_q)));

  // R3: only the key opens the block
  a_r3_key_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> ($past(wr_data_i) == OPEN_KEY));
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic             step;

  always_comb begin
    step     = run_i & tick_i & ~start_i;
    cnt_n    = cnt_q;
    pend_n   = pend_q;
    expire_o = 1'b0;
    if (start_i) begin
      cnt_n  = tmo_i;
      pend_n = 1'b0;
    end else if (step) begin
      if (pend_q) begin
        cnt_n  = tmo_i;
        pend_n = 1'b0;
      end else if (cnt_q <= CNT_W'(1)) begin
        cnt_n    = '0;
        expire_o = 1'b1;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
    if (kick_i && !start_i)
      pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  // R4: a start loads the full timeout
  a_r4_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == $past(tmo_i)));

  // R5: a plain tick takes exactly one off
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !start_i && !kick_i && !pend_q && cnt_q > CNT_W'(1))
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R8: a pending kick reloads on the next tick
  a_r8_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !start_i && pend_q) |=> (cnt_q == $past(tmo_i)));
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fire_i,
  output logic rst_o
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left_q, left_n;
  logic          on_q, on_n;

  always_comb begin
    left_n = left_q;
    on_n   = on_q;
    if (fire_i) begin
      left_n = PW'(PULSE_TICKS);
      on_n   = 1'b1;
    end else if (on_q && tick_i) begin
      left_n = left_q - PW'(1);
      if (left_q == PW'(1))
        on_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      on_q   <= 1'b0;
    end else begin
      left_q <= left_n;
      on_q   <= on_n;
    end
  end

  assign rst_o = on_q;

  // R6: the pulse only starts on an expiry
  a_r6_rise_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> $past(fire_i));

  // R6: the pulse level moves only on ticks or expiry
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !fire_i) |=> $stable(on_q));
endmodule

// File: rtl/keylock_wdt.sv
module keylock_wdt
  import kwdt_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              mod_en_i,
  input  logic              clk_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              wdt_rst_o
);
  logic             tick_en, expire, run, rsten, start, kick;
  logic [CNT_W-1:0] tmo;

  assign tick_en = tick_i & clk_en_i & mod_en_i;

  kwdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mod_en_i(mod_en_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .expire_i(expire), .rd_data_o(rd_data_o), .tmo_o(tmo), .run_o(run),
    .rsten_o(rsten), .start_o(start), .kick_o(kick)
  );

  kwdt_count u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .run_i(run),
    .start_i(start), .kick_i(kick), .tmo_i(tmo), .expire_o(expire)
  );

  kwdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .fire_i(expire & rsten),
    .rst_o(wdt_rst_o)
  );

  // R9: no expiry without an enabled tick
  a_r9_gated_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (clk_en_i && mod_en_i));

  // R7: expiry stops the counter
  a_r7_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_en_i) |=> !run);
endmodule

// File: tb/test_keylock_wdt.sv
module test_keylock_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, mod_en_i = 1'b1, clk_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        wdt_rst_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  keylock_wdt i_keylock_wdt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mod_en_i(mod_en_i),
    .clk_en_i(clk_en_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    rd_addr_i = a;
    #1;
    chk(req, {16'h0, rd_data_o}, {16'h0, exp});
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic arm(input logic [31:0] load, input logic [15:0] ctl);
    wr(8'hA0, 16'hE551);
    wr(8'h80, load[15:0]);
    wr(8'h84, load[31:16]);
    wr(8'h88, ctl);
  endtask

  task automatic drain_pulse(input string req);
    ticks(3);
    chk({req, " pulse held 3 ticks"}, {31'h0, wdt_rst_o}, 32'h1);
    ticks(1);
    chk({req, " pulse ends on 4th tick"}, {31'h0, wdt_rst_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1 lo", 8'h80, 16'h0);
    rd("R1 hi", 8'h84, 16'h0);
    rd("R1 ctrl", 8'h88, 16'h0);
    rd("R1 lock", 8'hA0, 16'h0);
    chk("R1 rst_o", {31'h0, wdt_rst_o}, 32'h0);

    // R2 locked writes ignored
    wr(8'h80, 16'h55AA);
    rd("R2 lo locked", 8'h80, 16'h0);
    wr(8'h88, 16'h000A);
    rd("R2 ctrl locked", 8'h88, 16'h0);
    ticks(3);
    chk("R2 no start when locked", {31'h0, wdt_rst_o}, 32'h0);

    // R3 key and relock
    wr(8'hA0, 16'hE551);
    rd("R3 unlocked", 8'hA0, 16'h1);
    wr(8'hA0, 16'hE550);
    rd("R3 relocked", 8'hA0, 16'h0);
    wr(8'h84, 16'h0007);
    rd("R3 hi after relock", 8'h84, 16'h0);

    // R10 read-back map
    wr(8'hA0, 16'hE551);
    wr(8'h80, 16'h55AA);
    wr(8'h84, 16'h1234);
    rd("R10 lo", 8'h80, 16'h55AA);
    rd("R10 hi", 8'h84, 16'h1234);
    wr(8'h88, 16'hFFFF);
    rd("R10 ctrl bits", 8'h88, 16'h000A);
    wr(8'h88, 16'h0000);
    rd("R10 ctrl clear", 8'h88, 16'h0000);
    rd("R10 unused offset", 8'h8C, 16'h0000);

    // R9 writes ignored with module disabled
    mod_en_i = 1'b0;
    wr(8'h80, 16'hBEEF);
    mod_en_i = 1'b1;
    rd("R9 write gated", 8'h80, 16'h55AA);

    // R5/R6/R7 sweep of small loads
    for (int l = 0; l <= 12; l++) begin
      int e;
      e = (l == 0) ? 1 : l;
      arm(l, 16'h000A);
      ticks(e - 1);
      chk($sformatf("R5 no expiry before tick %0d (L=%0d)", e, l), {31'h0, wdt_rst_o}, 32'h0);
      ticks(1);
      chk($sformatf("R6 reset at tick %0d (L=%0d)", e, l), {31'h0, wdt_rst_o}, 32'h1);
      rd("R7 run cleared", 8'h88, 16'h0008);
      drain_pulse("R6");
    end

    // R4/R5 high half counts
    arm(32'h0001_0000, 16'h000A);
    ticks(65535);
    chk("R4 high half no early expiry", {31'h0, wdt_rst_o}, 32'h0);
    ticks(1);
    chk("R5 expiry at 65536", {31'h0, wdt_rst_o}, 32'h1);
    drain_pulse("R6 long");

    // R7 reset disabled
    arm(3, 16'h0002);
    ticks(3);
    chk("R7 no pulse when disabled", {31'h0, wdt_rst_o}, 32'h0);
    rd("R7 run cleared no rsten", 8'h88, 16'h0000);
    ticks(5);
    chk("R7 stays quiet", {31'h0, wdt_rst_o}, 32'h0);

    // R8 kick
    arm(5, 16'h000A);
    ticks(3);
    wr(8'h80, 16'h0006);
    ticks(6);
    chk("R8 kick delays expiry", {31'h0, wdt_rst_o}, 32'h0);
    ticks(1);
    chk("R8 expiry after reload", {31'h0, wdt_rst_o}, 32'h1);
    drain_pulse("R8");

    // R9 clock enable and module enable gate counting
    arm(2, 16'h000A);
    clk_en_i = 1'b0;
    ticks(5);
    clk_en_i = 1'b1;
    ticks(1);
    chk("R9 clk_en gates ticks", {31'h0, wdt_rst_o}, 32'h0);
    mod_en_i = 1'b0;
    ticks(5);
    mod_en_i = 1'b1;
    chk("R9 mod_en gates ticks", {31'h0, wdt_rst_o}, 32'h0);
    ticks(1);
    chk("R9 expiry after enabled ticks", {31'h0, wdt_rst_o}, 32'h1);
    drain_pulse("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule